// File: doc/BRIEF.md
# Processor Stop-Clock Power State Controller

This block holds the low-power state of one processor core. A halt or monitor-wait instruction takes the core out of normal execution into halt and produces a one-cycle halt bus-cycle pulse. An active-low stop-clock request parks the core in stop grant. A cache snoop that arrives in either low-power state is serviced in a dedicated snoop state. When the snoop is done, the controller goes back to the low-power state it left. A break event (init, bus init, maskable or non-maskable interrupt, system-management interrupt, reset request or bus interrupt) takes the core out of halt.

When the extended mode is enabled and the core is not already at its lowest point, halt entry saves the current voltage-ID and ratio selects and drops both to their lowest values. On exit, the voltage-ID is restored first. A programmable settle count then runs, and only after it does the ratio come back. The controller reports normal state only once the ratio is restored. In normal execution the two operating-point outputs follow the requested values.

Top module: `stopclk_pm_ctrl`

## Requirements
- R1: After reset, `state_o` is 0 (normal), `vid_o` is VID_DEFAULT, `ratio_o` is RATIO_DEFAULT, and `halt_cycle_o` and `snoop_svc_o` are 0.
- R2: In normal (code 0) with `stpclk_ni` high, `halt_instr_i` moves the controller to halt (code 1) at the next edge. At that same edge `halt_cycle_o` goes high for exactly one cycle.
- R3: In halt, any set bit of `break_i` ends halt. Plain halt returns to normal (code 0) at the next edge. Extended halt starts the exit sequence of R10.
- R4: In halt, a break event wins over a same-cycle stop-clock assertion. In normal, a stop-clock assertion wins over a same-cycle halt instruction, and the instruction is dropped.
- R5: `stpclk_ni` low in normal or halt moves the controller to stop grant (code 2). It stays there while the input is low, ignoring breaks and halt instructions. When the input goes high, it returns to the state it came from.
- R6: `snoop_req_i` in halt moves to halt-snoop (code 3), and in stop grant (input still low) to stop-grant-snoop (code 4). `snoop_done_i` returns to halt or stop grant respectively. A snoop request has no effect in the other states.
- R7: `snoop_svc_o` is high exactly while `state_o` is 3 or 4.
- R8: In normal, `vid_o` and `ratio_o` take `vid_req_i` and `ratio_req_i` at each edge. In any other state they are held except by R8 entry and R10 exit. Extended-halt entry sets them to VID_LOW and RATIO_LOW and saves the previous values.
- R9: With `xhalt_en_i` low, or with `vid_o`/`ratio_o` already equal to VID_LOW/RATIO_LOW, halt entry is plain. The operating point is left unchanged throughout halt.
- R10: On a break from extended halt, `vid_o` returns to its saved value at that edge. `ratio_o` returns to its saved value `settle_cycles_i`+1 edges later, and `state_o` changes from 1 to 0 at that same edge. All inputs except reset are ignored during the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| halt_instr_i | input | 1 | Halt or monitor-wait instruction retired |
| xhalt_en_i | input | 1 | Enables operating-point lowering on halt |
| break_i | input | NUM_BREAK | Break event lines, any bit set ends halt |
| stpclk_ni | input | 1 | Stop-clock request, active low |
| snoop_req_i | input | 1 | Snoop occurred strobe |
| snoop_done_i | input | 1 | Snoop serviced strobe |
| vid_req_i | input | VID_W | Voltage-ID requested in normal execution |
| ratio_req_i | input | RATIO_W | Core-to-bus ratio requested in normal execution |
| settle_cycles_i | input | SETTLE_W | Extra cycles between voltage and ratio restore |
| state_o | output | 3 | 0 normal, 1 halt, 2 stop grant, 3 halt snoop, 4 stop-grant snoop |
| halt_cycle_o | output | 1 | One-cycle halt bus-cycle pulse |
| snoop_svc_o | output | 1 | Cache snoop service enable |
| vid_o | output | VID_W | Voltage-ID select |
| ratio_o | output | RATIO_W | Core-to-bus ratio select |

## Verification
Random traffic mixes halt instructions, rare break events, long and short stop-clock pulses and snoop handshakes. The requested operating point lands on the lowest point often enough that plain halt and extended halt both occur. Same-cycle collisions of break and stop-clock, and of halt and stop-clock, separate the two priority orders. A long settle count shows that voltage and ratio are restored in separate cycles, and in the right order, rather than together. A stop-grant episode that starts from halt, compared with one that starts from normal, shows that the return state is remembered.

// File: rtl/stopclk_pm_pkg.sv
package stopclk_pm_pkg;
  typedef enum logic [2:0] {
    ST_NORMAL   = 3'd0,
    ST_HALT     = 3'd1,
    ST_STOPGNT  = 3'd2,
    ST_HALT_SNP = 3'd3,
    ST_SG_SNP   = 3'd4,
    ST_XH_EXIT  = 3'd5
  } pm_state_e;

  // exit sequencing is reported as halt
  function automatic logic [2:0] report_code(pm_state_e s);
    return (s == ST_XH_EXIT) ? 3'd1 : 3'(s);
  endfunction
endpackage

// File: rtl/stopclk_pm_fsm.sv
module stopclk_pm_fsm
  import stopclk_pm_pkg::*;
#(
  parameter int NUM_BREAK = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 halt_instr_i,
  input  logic                 xhalt_en_i,
  input  logic [NUM_BREAK-1:0] break_i,
  input  logic                 stpclk_ni,
  input  logic                 snoop_req_i,
  input  logic                 snoop_done_i,
  input  logic                 at_low_i,
  input  logic                 settle_done_i,
  output logic [2:0]           state_o,
  output logic                 halt_cycle_o,
  output logic                 snoop_svc_o,
  output logic                 track_o,
  output logic                 lower_o,
  output logic                 restore_vid_o,
  output logic                 restore_ratio_o
);
  pm_state_e state_q, state_d, ret_q, ret_d;
  logic      xh_q, xh_d, hc_d;
  logic      brk_any;

  assign brk_any = |break_i;

  always_comb begin
    state_d         = state_q;
    ret_d           = ret_q;
    xh_d            = xh_q;
    hc_d            = 1'b0;
    track_o         = 1'b0;
    lower_o         = 1'b0;
    restore_vid_o   = 1'b0;
    restore_ratio_o = 1'b0;
    unique case (state_q)
      ST_NORMAL: begin
        track_o = 1'b1;
        if (!stpclk_ni) begin
          state_d = ST_STOPGNT;
          ret_d   = ST_NORMAL;
        end else if (halt_instr_i) begin
          state_d = ST_HALT;
          hc_d    = 1'b1;
          if (xhalt_en_i && !at_low_i) begin
            lower_o = 1'b1;
            track_o = 1'b0;
            xh_d    = 1'b1;
          end
        end
      end
      ST_HALT: begin
        if (brk_any) begin
          if (xh_q) begin
            state_d       = ST_XH_EXIT;
            restore_vid_o = 1'b1;
          end else begin
            state_d = ST_NORMAL;
          end
        end else if (!stpclk_ni) begin
          state_d = ST_STOPGNT;
          ret_d   = ST_HALT;
        end else if (snoop_req_i) begin
          state_d = ST_HALT_SNP;
        end
      end
      ST_XH_EXIT: begin
        if (settle_done_i) begin
          restore_ratio_o = 1'b1;
          xh_d            = 1'b0;
          state_d         = ST_NORMAL;
        end
      end
      ST_STOPGNT: begin
        if (stpclk_ni)        state_d = ret_q;
        else if (snoop_req_i) state_d = ST_SG_SNP;
      end
      ST_HALT_SNP: if (snoop_done_i) state_d = ST_HALT;
      ST_SG_SNP:   if (snoop_done_i) state_d = ST_STOPGNT;
      default:     state_d = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_NORMAL;
      ret_q        <= ST_NORMAL;
      xh_q         <= 1'b0;
      halt_cycle_o <= 1'b0;
    end else begin
      state_q      <= state_d;
      ret_q        <= ret_d;
      xh_q         <= xh_d;
      halt_cycle_o <= hc_d;
    end
  end

  assign state_o     = report_code(state_q);
  assign snoop_svc_o = (state_q == ST_HALT_SNP) || (state_q == ST_SG_SNP);
endmodule

// File: rtl/stopclk_pm_oppt.sv
module stopclk_pm_oppt #(
  parameter int                 VID_W         = 8,
  parameter int                 RATIO_W       = 6,
  parameter int                 SETTLE_W      = 8,
  parameter logic [VID_W-1:0]   VID_DEFAULT   = '0,
  parameter logic [VID_W-1:0]   VID_LOW       = '0,
  parameter logic [RATIO_W-1:0] RATIO_DEFAULT = '0,
  parameter logic [RATIO_W-1:0] RATIO_LOW     = '0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                track_i,
  input  logic                lower_i,
  input  logic                restore_vid_i,
  input  logic                restore_ratio_i,
  input  logic [VID_W-1:0]    vid_req_i,
  input  logic [RATIO_W-1:0]  ratio_req_i,
  input  logic [SETTLE_W-1:0] settle_cycles_i,
  output logic [VID_W-1:0]    vid_o,
  output logic [RATIO_W-1:0]  ratio_o,
  output logic                at_low_o,
  output logic                settle_done_o
);
  logic [VID_W-1:0]    vid_sv_q;
  logic [RATIO_W-1:0]  ratio_sv_q;
  logic [SETTLE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vid_o      <= VID_DEFAULT;
      ratio_o    <= RATIO_DEFAULT;
      vid_sv_q   <= VID_DEFAULT;
      ratio_sv_q <= RATIO_DEFAULT;
    end else begin
      if (lower_i) begin
        vid_sv_q   <= vid_o;
        ratio_sv_q <= ratio_o;
        vid_o      <= VID_LOW;
        ratio_o    <= RATIO_LOW;
      end else if (track_i) begin
        vid_o   <= vid_req_i;
        ratio_o <= ratio_req_i;
      end
      if (restore_vid_i)   vid_o   <= vid_sv_q;
      if (restore_ratio_i) ratio_o <= ratio_sv_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (restore_vid_i)   cnt_q <= settle_cycles_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign settle_done_o = (cnt_q == '0);
  assign at_low_o      = (vid_o == VID_LOW) && (ratio_o == RATIO_LOW);
endmodule

// File: rtl/stopclk_pm_ctrl.sv
module stopclk_pm_ctrl #(
  parameter int                 NUM_BREAK     = 7,
  parameter int                 VID_W         = 8,
  parameter int                 RATIO_W       = 6,
  parameter int                 SETTLE_W      = 8,
  parameter logic [VID_W-1:0]   VID_DEFAULT   = 8'h40,
  parameter logic [VID_W-1:0]   VID_LOW       = 8'h10,
  parameter logic [RATIO_W-1:0] RATIO_DEFAULT = 6'd20,
  parameter logic [RATIO_W-1:0] RATIO_LOW     = 6'd6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 halt_instr_i,
  input  logic                 xhalt_en_i,
  input  logic [NUM_BREAK-1:0] break_i,
  input  logic                 stpclk_ni,
  input  logic                 snoop_req_i,
  input  logic                 snoop_done_i,
  input  logic [VID_W-1:0]     vid_req_i,
  input  logic [RATIO_W-1:0]   ratio_req_i,
  input  logic [SETTLE_W-1:0]  settle_cycles_i,
  output logic [2:0]           state_o,
  output logic                 halt_cycle_o,
  output logic                 snoop_svc_o,
  output logic [VID_W-1:0]     vid_o,
  output logic [RATIO_W-1:0]   ratio_o
);
  logic track, lower, restore_vid, restore_ratio, at_low, settle_done;

  stopclk_pm_fsm #(.NUM_BREAK(NUM_BREAK)) u_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .halt_instr_i    (halt_instr_i),
    .xhalt_en_i      (xhalt_en_i),
    .break_i         (break_i),
    .stpclk_ni       (stpclk_ni),
    .snoop_req_i     (snoop_req_i),
    .snoop_done_i    (snoop_done_i),
    .at_low_i        (at_low),
    .settle_done_i   (settle_done),
    .state_o         (state_o),
    .halt_cycle_o    (halt_cycle_o),
    .snoop_svc_o     (snoop_svc_o),
    .track_o         (track),
    .lower_o         (lower),
    .restore_vid_o   (restore_vid),
    .restore_ratio_o (restore_ratio)
  );

  stopclk_pm_oppt #(
    .VID_W(VID_W), .RATIO_W(RATIO_W), .SETTLE_W(SETTLE_W),
    .VID_DEFAULT(VID_DEFAULT), .VID_LOW(VID_LOW),
    .RATIO_DEFAULT(RATIO_DEFAULT), .RATIO_LOW(RATIO_LOW)
  ) u_oppt (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .track_i         (track),
    .lower_i         (lower),
    .restore_vid_i   (restore_vid),
    .restore_ratio_i (restore_ratio),
    .vid_req_i       (vid_req_i),
    .ratio_req_i     (ratio_req_i),
    .settle_cycles_i (settle_cycles_i),
    .vid_o           (vid_o),
    .ratio_o         (ratio_o),
    .at_low_o        (at_low),
    .settle_done_o   (settle_done)
  );
endmodule

// File: rtl/stopclk_pm_chk.sv
module stopclk_pm_chk #(
  parameter int VID_W   = 8,
  parameter int RATIO_W = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               halt_instr_i,
  input logic               stpclk_ni,
  input logic               snoop_req_i,
  input logic               snoop_done_i,
  input logic [VID_W-1:0]   vid_req_i,
  input logic [RATIO_W-1:0] ratio_req_i,
  input logic [2:0]         state_o,
  input logic               halt_cycle_o,
  input logic               snoop_svc_o,
  input logic [VID_W-1:0]   vid_o,
  input logic [RATIO_W-1:0] ratio_o
);
  p_halt_entry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd0 && stpclk_ni && halt_instr_i) |=> (state_o == 3'd1 && halt_cycle_o));

  p_halt_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_cycle_o |=> !halt_cycle_o);

  p_stpclk_enter_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd0 && !stpclk_ni) |=> state_o == 3'd2);

  p_sg_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd2 && !stpclk_ni && !snoop_req_i) |=> state_o == 3'd2);

  p_sg_snoop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd2 && !stpclk_ni && snoop_req_i) |=> state_o == 3'd4);

  p_snoop_back_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4 && snoop_done_i) |=> state_o == 3'd2);

  p_svc_state_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_svc_o |-> (state_o == 3'd3 || state_o == 3'd4));

  p_normal_track_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd0 && stpclk_ni && !halt_instr_i)
      |=> (vid_o == $past(vid_req_i) && ratio_o == $past(ratio_req_i)));

  p_ratio_hold_halt_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_o) == 3'd1 && state_o == 3'd1) |-> $stable(ratio_o));
endmodule

bind stopclk_pm_ctrl stopclk_pm_chk #(.VID_W(VID_W), .RATIO_W(RATIO_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .halt_instr_i (halt_instr_i),
  .stpclk_ni    (stpclk_ni),
  .snoop_req_i  (snoop_req_i),
  .snoop_done_i (snoop_done_i),
  .vid_req_i    (vid_req_i),
  .ratio_req_i  (ratio_req_i),
  .state_o      (state_o),
  .halt_cycle_o (halt_cycle_o),
  .snoop_svc_o  (snoop_svc_o),
  .vid_o        (vid_o),
  .ratio_o      (ratio_o)
);

// File: tb/sim_stopclk_pm_ctrl.sv
`timescale 1ns/1ps
module sim_stopclk_pm_ctrl;
  localparam int NB = 7;
  localparam logic [7:0] VD = 8'h40, VL = 8'h10;
  localparam logic [5:0] RD = 6'd20, RL = 6'd6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic h = 0, xe = 0, sn = 1, sq = 0, sd = 0;
  logic [NB-1:0] brk = '0;
  logic [7:0] vr = VD, settle = '0;
  logic [5:0] rr = RD;
  logic [2:0] st_o;
  logic hc_o, svc_o;
  logic [7:0] vid_o;
  logic [5:0] ratio_o;

  always #4 clk = ~clk;

  stopclk_pm_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .halt_instr_i(h), .xhalt_en_i(xe), .break_i(brk),
    .stpclk_ni(sn), .snoop_req_i(sq), .snoop_done_i(sd), .vid_req_i(vr),
    .ratio_req_i(rr), .settle_cycles_i(settle), .state_o(st_o),
    .halt_cycle_o(hc_o), .snoop_svc_o(svc_o), .vid_o(vid_o), .ratio_o(ratio_o)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // model: 0 N,1 H,2 SG,3 HS,4 SGS,5 exit
  int m_st = 0, m_ret = 0, m_cnt = 0;
  bit m_xh = 0, m_hc = 0;
  logic [7:0] m_vid = VD, m_sv = VD;
  logic [5:0] m_rat = RD, m_sr = RD;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_code(int s);
    return (s == 5) ? 1 : s;
  endfunction

  task automatic model_update();
    m_hc = 0;
    case (m_st)
      0: begin
        if (sn && h && xe && !(m_vid == VL && m_rat == RL)) begin
          m_sv = m_vid; m_sr = m_rat; m_vid = VL; m_rat = RL; m_xh = 1;
        end else begin
          m_vid = vr; m_rat = rr;
        end
        if (!sn) begin m_st = 2; m_ret = 0; end
        else if (h) begin m_st = 1; m_hc = 1; end
      end
      1: begin
        if (|brk) begin
          if (m_xh) begin m_st = 5; m_vid = m_sv; m_cnt = int'(settle); end
          else m_st = 0;
        end else if (!sn) begin m_st = 2; m_ret = 1; end
        else if (sq) m_st = 3;
      end
      5: begin
        if (m_cnt == 0) begin m_rat = m_sr; m_xh = 0; m_st = 0; end
        else m_cnt--;
      end
      2: if (sn) m_st = m_ret; else if (sq) m_st = 4;
      3: if (sd) m_st = 1;
      4: if (sd) m_st = 2;
      default: m_st = 0;
    endcase
  endtask

  task automatic check_all();
    string ts, tv;
    case (m_st)
      0: ts = "R3";
      1: ts = "R2";
      2: ts = "R5";
      5: ts = "R10";
      default: ts = "R6";
    endcase
    if (m_st == 5 || (m_st == 0 && m_xh == 0 && m_rat == m_sr && m_vid == m_sv)) tv = "R10";
    else if (m_st == 1 && !m_xh) tv = "R9";
    else tv = "R8";
    chk(ts, int'(st_o), exp_code(m_st));
    chk("R2", int'(hc_o), int'(m_hc));
    chk("R7", int'(svc_o), int'(m_st == 3 || m_st == 4));
    chk(tv, int'(vid_o), int'(m_vid));
    chk(tv, int'(ratio_o), int'(m_rat));
  endtask

  // called at a negedge with inputs already set
  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    check_all();
  endtask

  task automatic idle();
    h = 0; brk = '0; sq = 0; sd = 0; sn = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", int'(st_o), 0);
    chk("R1", int'(vid_o), int'(VD));
    chk("R1", int'(ratio_o), int'(RD));
    chk("R1", int'(hc_o), 0);
    chk("R1", int'(svc_o), 0);
    rst_n = 1'b1;

    // R10 extended exit ordering, settle=5
    idle(); settle = 8'd5; vr = 8'h55; rr = 6'd30; step();
    h = 1; xe = 1; step(); h = 0;
    chk("R8", int'(vid_o), int'(VL));
    chk("R8", int'(ratio_o), int'(RL));
    step();
    brk = 7'b0000100; step(); brk = '0;
    chk("R10", int'(vid_o), 8'h55);
    chk("R10", int'(ratio_o), int'(RL));
    for (int i = 0; i < 5; i++) begin
      step();
      chk("R10", int'(st_o), 1);
      chk("R10", int'(ratio_o), int'(RL));
    end
    step();
    chk("R10", int'(st_o), 0);
    chk("R10", int'(ratio_o), 30);

    // R9 already at lowest point
    vr = VL; rr = RL; step();
    h = 1; xe = 1; step(); h = 0;
    chk("R9", int'(st_o), 1);
    brk = 7'b1000000; step(); brk = '0;
    chk("R9", int'(st_o), 0);
    chk("R9", int'(vid_o), int'(VL));

    // R4 priorities
    vr = 8'h33; rr = 6'd12; xe = 0; h = 1; step(); h = 0;
    brk = 7'b0000001; sn = 0; step(); brk = '0; sn = 1;
    chk("R4", int'(st_o), 0);
    sn = 0; h = 1; step(); h = 0;
    chk("R4", int'(st_o), 2);
    chk("R4", int'(hc_o), 0);
    sn = 1; step();
    chk("R5", int'(st_o), 0);

    // R5/R6 stop grant from halt, snoop inside stop grant
    h = 1; step(); h = 0;
    sn = 0; step();
    sq = 1; step(); sq = 0;
    chk("R6", int'(st_o), 4);
    sd = 1; step(); sd = 0;
    chk("R6", int'(st_o), 2);
    sn = 1; step();
    chk("R5", int'(st_o), 1);
    brk = 7'b0010000; step(); brk = '0;

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      int r;
      if (n % 200 == 0) settle = 8'($urandom_range(0, 4));
      h   = ($urandom_range(0, 99) < 20);
      xe  = ($urandom_range(0, 99) < 60);
      brk = ($urandom_range(0, 99) < 8) ? NB'(1 << $urandom_range(0, NB - 1)) : '0;
      r   = $urandom_range(0, 99);
      if (r < 6) sn = ~sn;
      sq  = ($urandom_range(0, 99) < 15);
      sd  = ($urandom_range(0, 99) < 30);
      if ($urandom_range(0, 99) < 10) begin
        if ($urandom_range(0, 99) < 30) begin vr = VL; rr = RL; end
        else begin vr = 8'($urandom); rr = 6'($urandom); end
      end
      step();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule